// File: doc/BRIEF.md
# LFSR-Encoded Coarse Period Counter

This block measures out the coarse part of a clock-divider period. Instead of a binary down-counter, it uses an 11-bit right-shifting Galois linear-feedback shift register. The programmed period length is therefore written as a register state, not as a binary number. A controller loads a state. Each count tick then advances the register by one step. When the register reaches the all-ones end state, the next tick produces a one-cycle terminal pulse and reloads the programmed state. The terminal pulse marks the end of the coarse portion of an output period.

For a binary coarse value c, the state to program is the one reached by stepping 2048-(c-2) times from 0x7FF. The usable range of c is 3 to 2049. The all-zero state lies off the sequence and parks the counter. With ticks on every cycle, the terminal pulse repeats every c-2 ticks.

The control is a three-state machine:
- **IDLE** is entered on reset and on loading zero. It ignores ticks.
- **COUNT** is entered on loading a nonzero state, or from FIRE when a cycle passes without a terminal tick. It steps the register on each tick.
- **FIRE** is entered from COUNT or FIRE when a tick meets the end state. It drives the terminal output for that cycle. A FIRE followed by another terminal tick stays in FIRE.
- A load moves the machine from any state to COUNT or IDLE, and it overrides any tick in the same cycle.

Top module: `lfsr_coarse_counter`

## Requirements
- R1: After reset, `term_o` is low, the register is zero, and no terminal pulse appears until a nonzero state is loaded, whatever `cnt_en_i` does.
- R2: One step shifts the state right by one bit. When the bit shifted out of bit 0 is 1, the result is XORed with 0x500. The sequence from 0x7FF repeats every 2047 steps.
- R3: A cycle with `load_i` high copies `load_state_i` into both the working register and the reload register. A tick in that same cycle has no effect, and no terminal pulse follows that cycle.
- R4: A tick while the working register holds 0x7FF makes `term_o` high for exactly the next cycle. In that same step, the working register takes the reload value.
- R5: After loading the state for coarse value c (3 to 2049), the first terminal pulse comes on the (c-2)th tick, and every following pulse comes c-2 ticks after the previous one. For c=3 the loaded state is 0x7FF, and every tick produces a pulse.
- R6: Loading zero parks the counter: it never produces a terminal pulse, however many ticks arrive, until a nonzero load.
- R7: Cycles with `cnt_en_i` low neither advance the count nor produce a pulse. Counting resumes where it stopped.
- R8: The state for coarse value c is the one reached after 2048-(c-2) steps from 0x7FF, and the counter honours this mapping at both ends of the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load strobe for a new programmed state |
| load_state_i | input | 11 | LFSR state encoding the coarse length; zero parks the counter |
| cnt_en_i | input | 1 | Count tick enable |
| term_o | output | 1 | One-cycle terminal pulse that ends a coarse period |

## Verification
A load and a terminal tick can fall in the same cycle. The bench provokes this by loading a short period and letting the register run to 0x7FF. In the cycle that would fire, it raises the load together with the tick. The scoreboard then expects no pulse from the old period, and it expects the next pulse exactly at the new period's length counted from the load. A stray pulse shows up as an interval of zero, or as an unexpected pulse.

// File: rtl/lfsr_cnt_pkg.sv
package lfsr_cnt_pkg;

    localparam int unsigned LC_WIDTH   = 11;
    localparam logic [LC_WIDTH-1:0] LC_TAPS = 11'h500;
    localparam logic [LC_WIDTH-1:0] LC_END  = 11'h7FF;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_COUNT = 2'd1,
        CS_FIRE  = 2'd2
    } cnt_state_e;

endpackage

// File: rtl/lfsr_cnt_step.sv
module lfsr_cnt_step #(
    parameter int unsigned WIDTH = 11,
    parameter logic [WIDTH-1:0] TAPS = 11'h500
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] nxt_o
);

    logic out_bit;
    assign out_bit = cur_i[0];

    // Right shift; the bit leaving position 0 feeds the tapped positions.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (b == WIDTH - 1) begin : g_top
            assign nxt_o[b] = TAPS[b] & out_bit;
        end else begin : g_mid
            assign nxt_o[b] = cur_i[b+1] ^ (TAPS[b] & out_bit);
        end
    end

endmodule

// File: rtl/lfsr_cnt_datapath.sv
module lfsr_cnt_datapath #(
    parameter int unsigned WIDTH = 11,
    parameter logic [WIDTH-1:0] TAPS = 11'h500,
    parameter logic [WIDTH-1:0] END_STATE = 11'h7FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_state_i,
    input  logic             step_en_i,
    input  logic             reload_en_i,
    output logic             at_end_o,
    output logic             load_zero_o,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] reload_o
);

    logic [WIDTH-1:0] work_q;
    logic [WIDTH-1:0] rel_q;
    logic [WIDTH-1:0] step_nxt;

    lfsr_cnt_step #(
        .WIDTH (WIDTH),
        .TAPS  (TAPS)
    ) u_step (
        .cur_i (work_q),
        .nxt_o (step_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q <= '0;
            rel_q  <= '0;
        end else if (load_i) begin
            work_q <= load_state_i;
            rel_q  <= load_state_i;
        end else if (reload_en_i) begin
            work_q <= rel_q;
        end else if (step_en_i) begin
            work_q <= step_nxt;
        end
    end

    assign at_end_o    = (work_q == END_STATE);
    assign load_zero_o = (load_state_i == '0);
    assign cur_o       = work_q;
    assign reload_o    = rel_q;

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_en_i && !reload_en_i) |=> $stable(work_q)); // R7

    AST_RELOAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(rel_q)); // R3

endmodule

// File: rtl/lfsr_cnt_fsm.sv
module lfsr_cnt_fsm
    import lfsr_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic load_zero_i,
    input  logic tick_i,
    input  logic at_end_i,
    output logic step_en_o,
    output logic reload_en_o,
    output logic running_o,
    output logic term_o
);

    cnt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = load_zero_i ? CS_IDLE : CS_COUNT;
        end else begin
            unique case (state_q)
                CS_IDLE:  state_d = CS_IDLE;
                CS_COUNT: state_d = (tick_i && at_end_i) ? CS_FIRE : CS_COUNT;
                CS_FIRE:  state_d = (tick_i && at_end_i) ? CS_FIRE : CS_COUNT;
                default:  state_d = CS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        running_o   = 1'b0;
        term_o      = 1'b0;
        unique case (state_q)
            CS_IDLE:  running_o = 1'b0;
            CS_COUNT: running_o = 1'b1;
            CS_FIRE: begin
                running_o = 1'b1;
                term_o    = 1'b1;
            end
            default:  running_o = 1'b0;
        endcase
        step_en_o   = tick_i && running_o && !load_i && !at_end_i;
        reload_en_o = tick_i && running_o && !load_i &&  at_end_i;
    end

    AST_TERM_NEEDS_END_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_o) |-> $past(tick_i && at_end_i && !load_i)); // R4

    AST_LOAD_BLOCKS_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !term_o); // R3

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_IDLE && !load_i) |=> (state_q == CS_IDLE && !term_o)); // R6

    AST_NO_TICK_NO_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !term_o); // R7

endmodule

// File: rtl/lfsr_coarse_counter.sv
module lfsr_coarse_counter
    import lfsr_cnt_pkg::*;
#(
    parameter int unsigned WIDTH = LC_WIDTH,
    parameter logic [WIDTH-1:0] TAPS = LC_TAPS,
    parameter logic [WIDTH-1:0] END_STATE = LC_END
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_state_i,
    input  logic             cnt_en_i,
    output logic             term_o
);

    logic             at_end;
    logic             load_zero;
    logic             step_en;
    logic             reload_en;
    logic             running;
    logic [WIDTH-1:0] cur_state;
    logic [WIDTH-1:0] reload_state;

    lfsr_cnt_datapath #(
        .WIDTH     (WIDTH),
        .TAPS      (TAPS),
        .END_STATE (END_STATE)
    ) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .load_state_i (load_state_i),
        .step_en_i    (step_en),
        .reload_en_i  (reload_en),
        .at_end_o     (at_end),
        .load_zero_o  (load_zero),
        .cur_o        (cur_state),
        .reload_o     (reload_state)
    );

    lfsr_cnt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .load_zero_i (load_zero),
        .tick_i      (cnt_en_i),
        .at_end_i    (at_end),
        .step_en_o   (step_en),
        .reload_en_o (reload_en),
        .running_o   (running),
        .term_o      (term_o)
    );

    AST_RUN_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cur_state != '0)); // R6

    AST_FIRE_RELOADED: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |-> (cur_state == reload_state)); // R4

    AST_STEP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt_en_i && !load_i) |=> (cur_state != '0)); // R2

endmodule

// File: tb/lfsr_coarse_counter_bench.sv
module lfsr_coarse_counter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [10:0] load_state_i = '0;
    logic        cnt_en_i = 1'b0;
    logic        term_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [10:0] tbl [0:2047];
    int exp_q [$];
    string ctx = "R1";

    longint ticks = 0;
    longint mark = 0;
    bit load_seen = 1'b0;

    always #2.5 clk = ~clk;

    lfsr_coarse_counter u_lfsr_coarse_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .load_state_i (load_state_i),
        .cnt_en_i     (cnt_en_i),
        .term_o       (term_o)
    );

    function automatic logic [10:0] mstep(input logic [10:0] s);
        return s[0] ? ((s >> 1) ^ 11'h500) : (s >> 1);
    endfunction

    // Tick bookkeeping: a tick in a load cycle does not count (R3).
    always @(posedge clk) begin
        if (load_i) begin
            load_seen <= 1'b1;
        end else begin
            load_seen <= 1'b0;
            if (cnt_en_i && rst_n) ticks <= ticks + 1;
        end
    end

    // Monitor: pops the expected interval for every pulse.
    always @(negedge clk) begin
        if (load_seen) mark = ticks;
        if (rst_n && term_o) begin
            longint got;
            got = ticks - mark;
            mark = ticks;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected pulse, actual interval=%0d expected=no pulse", ctx, got);
            end else begin
                int want;
                want = exp_q.pop_front();
                if (got != want) begin
                    errors++;
                    $display("FAIL %s: pulse interval actual=%0d expected=%0d", ctx, got, want);
                end
            end
        end
    end

    task automatic do_load(input logic [10:0] st, input logic en);
        @(negedge clk);
        load_i = 1'b1;
        load_state_i = st;
        cnt_en_i = en;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic expect_drained(input string req);
        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: pending pulses actual=%0d expected=0", req, exp_q.size());
            exp_q.delete();
        end
    endtask

    // R5 R8: two periods of coarse value c.
    task automatic run_coarse(input int c);
        ctx = (c == 3 || c == 2049) ? "R8" : "R5";
        do_load(tbl[c-2], 1'b0);
        exp_q.push_back(c - 2);
        exp_q.push_back(c - 2);
        cnt_en_i = 1'b1;
        repeat (2 * (c - 2)) @(negedge clk);
        cnt_en_i = 1'b0;
        expect_drained(ctx);
    endtask

    initial begin
        logic [10:0] s;
        s = 11'h7FF;
        for (int i = 2047; i > 0; i--) begin
            s = mstep(s);
            tbl[i] = s;
        end
        tbl[0] = '0;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (term_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: term_o in reset actual=%b expected=0", term_o);
        end
        rst_n = 1'b1;
        // R1: ticks after reset with nothing loaded give no pulse.
        ctx = "R1";
        cnt_en_i = 1'b1;
        repeat (60) @(negedge clk);
        cnt_en_i = 1'b0;
        expect_drained("R1");

        // R2: model period check, the table closes on the end state.
        checks++;
        if (tbl[1] !== 11'h7FF) begin
            errors++;
            $display("FAIL R2: state after 2047 steps actual=%h expected=7ff", tbl[1]);
        end

        for (int c = 3; c <= 34; c++) run_coarse(c);
        for (int c = 35; c < 2049; c += 113) run_coarse(c);
        run_coarse(2048);
        run_coarse(2049);

        // R7: pause in the middle of a period of 8 ticks (c=10).
        ctx = "R7";
        do_load(tbl[8], 1'b0);
        exp_q.push_back(8);
        exp_q.push_back(8);
        cnt_en_i = 1'b1;
        repeat (3) @(negedge clk);
        cnt_en_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            checks++;
            if (term_o !== 1'b0) begin
                errors++;
                $display("FAIL R7: term_o while paused actual=%b expected=0", term_o);
            end
        end
        cnt_en_i = 1'b1;
        repeat (13) @(negedge clk);
        cnt_en_i = 1'b0;
        expect_drained("R7");

        // R3: load coincides with the terminal tick of a c=6 period.
        ctx = "R3";
        do_load(tbl[4], 1'b0);
        cnt_en_i = 1'b1;
        repeat (3) @(negedge clk);
        load_i = 1'b1;
        load_state_i = tbl[3];
        exp_q.push_back(3);
        @(negedge clk);
        load_i = 1'b0;
        repeat (3) @(negedge clk);
        cnt_en_i = 1'b0;
        expect_drained("R3");

        // R4: back-to-back pulses at the shortest period (state 0x7FF).
        ctx = "R4";
        do_load(11'h7FF, 1'b0);
        for (int k = 0; k < 5; k++) exp_q.push_back(1);
        cnt_en_i = 1'b1;
        repeat (5) @(negedge clk);
        cnt_en_i = 1'b0;
        expect_drained("R4");

        // R6: zero load parks the counter past a full sequence length.
        ctx = "R6";
        do_load(11'h000, 1'b0);
        cnt_en_i = 1'b1;
        repeat (2100) @(negedge clk);
        cnt_en_i = 1'b0;
        expect_drained("R6");
        run_coarse(7);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule